// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache

This block is a small direct-mapped data cache that sits between one processor and a shared memory bus. Each line holds one data word together with a valid flag and an address tag. Loads that find a valid matching line return their data in the cycle they are presented. Loads that find no valid match fetch the word over the bus with a single-beat read and install it. Every store goes out on the bus as a single-beat write, so memory always holds the newest value. A store that finds its line resident also refreshes the cached word. A store that misses leaves the array untouched.

The cache also watches the writes that other agents put on the bus. When such a write names an address the cache holds, that line drops to invalid, and the next local load of that address goes back to memory. Any number of caches may hold a copy of a word for reading. Only a write removes the other copies. Bus arbitration is outside the block: the cache raises a request, holds its command, address and data steady, and the transaction completes in the one cycle in which the grant is seen.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid and `bus_req` and `cpu_ready` are low, so the first load of any address is a miss.
- R2: A load miss raises `bus_req` in the next cycle with `bus_cmd`=0 (read) and `bus_addr` equal to the load address. In the cycle `bus_gnt` is high, `cpu_ready` is high and `cpu_rdata` equals `bus_rdata`.
- R3: A load whose line is valid with a matching tag gets `cpu_ready` high in its first cycle, with the stored word on `cpu_rdata` and no bus request.
- R4: A store always goes on the bus with `bus_cmd`=1 (write), the store address and the store data. `cpu_ready` stays low until the grant cycle. If the line is resident, its word is replaced, so a following load hits and returns the stored value.
- R5: A store miss does not allocate a line, so a following load of that address is a miss.
- R6: A snooped write (`snoop_wr` high) whose `snoop_addr` matches a valid line invalidates it, so the next load of that address misses.
- R7: A snooped write to the same index with a different tag leaves the resident line valid.
- R8: When a snooped write names the address of a load that would hit in the same cycle, the snoop wins. `cpu_ready` stays low and the load is replayed as a bus read.
- R9: A snooped write to the address being filled, in the fill's grant cycle, still returns the bus data to the processor but does not install the line.
- R10: The index is the low 4 address bits and the tag is the remaining bits. A fill replaces whatever line shares its index, so the displaced address misses afterwards.
- R11: While `bus_req` is high and no grant has been seen, `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` keep their values. Only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd | output | 1 | 0 = read, 1 = write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data from memory, valid in the grant cycle |
| snoop_wr | input | 1 | Another agent writes on the bus this cycle |
| snoop_addr | input | ADDR_W | Address of that snooped write |

## Verification
A valid flag that failed to clear, or a fill that ought to have been suppressed, shows at the ports as a load that completes in its first cycle without any bus read. That is visible on the very next load of the address. A tag or data word left stale shows as a hit that returns a value different from the memory model's current word, because a write-through memory is always the reference for a hit. Stall or hand-off faults show in the request cycles themselves, as `cpu_ready` rising before the grant or as bus fields changing while the request waits.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } wtc_state_e;

  localparam logic CMD_RD = 1'b0;
  localparam logic CMD_WR = 1'b1;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic             sn_en,
  input  logic [IDX_W-1:0] sn_idx,
  input  logic [TAG_W-1:0] sn_tag,
  output logic             lk_hit,
  output logic             sn_hit
);
  localparam int LINES = 1 << IDX_W;

  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign sn_hit = sn_en && valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);

  // Invalidate first; a fill in the same cycle overrides (the fill is
  // already suppressed by the caller when both name the same address).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) valid_q[i] <= 1'b0;
    end else begin
      if (sn_hit)  valid_q[sn_idx] <= 1'b0;
      if (fill_en) valid_q[lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_idx] <= lk_tag;
  end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx] <= wr_data;
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              lk_hit,
  input  logic              clash,
  input  logic              bus_gnt,
  output wtc_state_e        state,
  output logic              bus_req,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              hit_serve,
  output logic              fill_en,
  output logic              upd_en,
  output logic              cpu_ready
);
  wtc_state_e        state_q;
  logic              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, start_bus, done;

  assign accept    = (state_q == ST_IDLE) && cpu_req;
  assign hit_serve = accept && !cpu_we && lk_hit && !clash;
  assign start_bus = accept && !hit_serve;
  assign done      = (state_q == ST_BUS) && bus_gnt;
  assign fill_en   = done && (cmd_q == CMD_RD) && !clash;
  assign upd_en    = done && (cmd_q == CMD_WR) && lk_hit && !clash;
  assign cpu_ready = hit_serve || done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_bus) begin
      state_q <= ST_BUS;
      cmd_q   <= cpu_we ? CMD_WR : CMD_RD;
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end else if (done) begin
      state_q <= ST_IDLE;
    end
  end

  assign state     = state_q;
  assign bus_req   = (state_q == ST_BUS);
  assign bus_cmd   = cmd_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_wr,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  // Named internal events, also observed by the bound checker.
  wtc_state_e        state_w;
  logic [ADDR_W-1:0] lkp_addr_w;
  logic              lk_hit_w, sn_hit_w, clash_w;
  logic              hit_serve_w, fill_w, upd_w;
  logic [DATA_W-1:0] arr_rdata_w;

  assign lkp_addr_w = (state_w == ST_IDLE) ? cpu_addr : bus_addr;
  assign clash_w    = snoop_wr && (snoop_addr == lkp_addr_w);

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .lk_hit    (lk_hit_w),
    .clash     (clash_w),
    .bus_gnt   (bus_gnt),
    .state     (state_w),
    .bus_req   (bus_req),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hit_serve (hit_serve_w),
    .fill_en   (fill_w),
    .upd_en    (upd_w),
    .cpu_ready (cpu_ready)
  );

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_idx  (idx_of(lkp_addr_w)),
    .lk_tag  (tag_of(lkp_addr_w)),
    .fill_en (fill_w),
    .sn_en   (snoop_wr),
    .sn_idx  (idx_of(snoop_addr)),
    .sn_tag  (tag_of(snoop_addr)),
    .lk_hit  (lk_hit_w),
    .sn_hit  (sn_hit_w)
  );

  wtc_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
    .clk     (clk),
    .wr_en   (fill_w || upd_w),
    .wr_idx  (idx_of(lkp_addr_w)),
    .wr_data (fill_w ? bus_rdata : bus_wdata),
    .rd_idx  (idx_of(lkp_addr_w)),
    .rd_data (arr_rdata_w)
  );

  assign cpu_rdata = (state_w == ST_BUS) ? bus_rdata : arr_rdata_w;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              snoop_wr,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              hit_serve,
  input logic              sn_hit
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !bus_req && !cpu_ready);

  a_r2_grant_completes: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |-> cpu_ready);

  a_r3_hit_stays_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
    hit_serve |-> !bus_req && !cpu_we);

  a_r4_store_waits_for_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> bus_req && bus_gnt && bus_cmd);

  a_r6_snooped_line_gone: assert property (@(posedge clk) disable iff (!rst_n)
    sn_hit |=> !(hit_serve && cpu_addr == $past(snoop_addr)));

  a_r8_snoop_beats_hit: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !bus_req && snoop_wr && snoop_addr == cpu_addr |-> !cpu_ready);

  a_r11_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)
                            && $stable(bus_wdata));
endmodule

bind wt_snoop_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cpu_ready  (cpu_ready),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .snoop_wr   (snoop_wr),
  .snoop_addr (snoop_addr),
  .hit_serve  (hit_serve_w),
  .sn_hit     (sn_hit_w)
);

// File: tb/wt_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module wt_snoop_cache_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ready, bus_req, bus_cmd;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          snoop_wr = 1'b0;
  logic [AW-1:0] snoop_addr = '0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] mem [256];

  always #2 clk = ~clk;

  wt_snoop_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One processor access; the bench plays memory and arbiter.
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit exp_hit, input int delay, input bit sn_first,
                        input bit sn_grant, input string req);
    logic [DW-1:0] rd_exp;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    rd_exp = mem[a[7:0]];
    if (sn_first) begin
      snoop_wr = 1'b1; snoop_addr = a; mem[a[7:0]] = mem[a[7:0]] ^ 32'h0F0F_0001;
    end
    #1;
    if (exp_hit) begin
      chk(cpu_ready && !bus_req, {req, " hit ready"}, {cpu_ready, bus_req}, 2'b10);
      chk(cpu_rdata == rd_exp, {req, " hit data"}, cpu_rdata, rd_exp);
      @(negedge clk);
      cpu_req = 1'b0; snoop_wr = 1'b0;
      return;
    end
    chk(!cpu_ready, {req, " no early ready"}, cpu_ready, 0);
    @(negedge clk);
    snoop_wr = 1'b0;
    for (int i = 0; i < delay; i++) begin
      #1;
      chk(bus_req && !cpu_ready && bus_cmd == we && bus_addr == a,
          {req, " R11 wait hold"}, {bus_req, cpu_ready, bus_cmd, bus_addr}, {2'b10, we, a});
      if (we) chk(bus_wdata == wd, {req, " R11 wdata"}, bus_wdata, wd);
      @(negedge clk);
    end
    bus_gnt = 1'b1;
    rd_exp = mem[a[7:0]];
    bus_rdata = rd_exp;
    if (we) mem[a[7:0]] = wd;
    if (sn_grant) begin
      snoop_wr = 1'b1; snoop_addr = a; mem[a[7:0]] = mem[a[7:0]] ^ 32'h00F0_0100;
    end
    #1;
    chk(bus_req && cpu_ready && bus_cmd == we && bus_addr == a,
        {req, " grant cycle"}, {bus_req, cpu_ready, bus_cmd, bus_addr}, {2'b11, we, a});
    if (we) chk(bus_wdata == wd, {req, " write data"}, bus_wdata, wd);
    else    chk(cpu_rdata == rd_exp, {req, " fill data"}, cpu_rdata, rd_exp);
    @(negedge clk);
    bus_gnt = 1'b0; cpu_req = 1'b0; snoop_wr = 1'b0;
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    @(negedge clk);
    snoop_wr = 1'b1; snoop_addr = a; mem[a[7:0]] = mem[a[7:0]] + 32'h33;
    @(negedge clk);
    snoop_wr = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(!bus_req && !cpu_ready, "R1 reset outputs", {bus_req, cpu_ready}, 0);
    access(1'b0, 16'h0010, '0, 1'b0, 2, 1'b0, 1'b0, "R1 R2 first load misses");
  endtask

  task automatic t_load_hit;
    access(1'b0, 16'h0010, '0, 1'b1, 0, 1'b0, 1'b0, "R3 load hit");
  endtask

  task automatic t_store_hit;
    access(1'b1, 16'h0010, 32'hCAFE_0010, 1'b0, 1, 1'b0, 1'b0, "R4 store hit bus write");
    access(1'b0, 16'h0010, '0, 1'b1, 0, 1'b0, 1'b0, "R4 load after store");
  endtask

  task automatic t_store_miss;
    access(1'b1, 16'h0025, 32'h1234_0025, 1'b0, 0, 1'b0, 1'b0, "R5 store miss write");
    access(1'b0, 16'h0025, '0, 1'b0, 1, 1'b0, 1'b0, "R5 no allocate");
  endtask

  task automatic t_snoop_inval;
    access(1'b0, 16'h0030, '0, 1'b0, 0, 1'b0, 1'b0, "R6 fill");
    access(1'b0, 16'h0030, '0, 1'b1, 0, 1'b0, 1'b0, "R6 resident");
    snoop(16'h0030);
    access(1'b0, 16'h0030, '0, 1'b0, 1, 1'b0, 1'b0, "R6 refetch after snoop");
  endtask

  task automatic t_snoop_other_tag;
    access(1'b0, 16'h0041, '0, 1'b0, 0, 1'b0, 1'b0, "R7 fill");
    snoop(16'h0051);
    access(1'b0, 16'h0041, '0, 1'b1, 0, 1'b0, 1'b0, "R7 other tag keeps line");
  endtask

  task automatic t_snoop_race;
    access(1'b0, 16'h0062, '0, 1'b0, 0, 1'b0, 1'b0, "R8 fill");
    access(1'b0, 16'h0062, '0, 1'b0, 1, 1'b1, 1'b0, "R8 snoop same cycle replays");
  endtask

  task automatic t_snoop_fill;
    access(1'b0, 16'h0073, '0, 1'b0, 1, 1'b0, 1'b1, "R9 snoop at fill grant");
    access(1'b0, 16'h0073, '0, 1'b0, 0, 1'b0, 1'b0, "R9 not installed");
  endtask

  task automatic t_conflict;
    access(1'b0, 16'h0084, '0, 1'b0, 0, 1'b0, 1'b0, "R10 fill first");
    access(1'b0, 16'h0094, '0, 1'b0, 0, 1'b0, 1'b0, "R10 fill same index");
    access(1'b0, 16'h0094, '0, 1'b1, 0, 1'b0, 1'b0, "R10 newcomer hits");
    access(1'b0, 16'h0084, '0, 1'b0, 2, 1'b0, 1'b0, "R10 displaced misses");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5000000 ^ (i * 32'h0001_0203);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_hit();
    t_store_hit();
    t_store_miss();
    t_snoop_inval();
    t_snoop_other_tag();
    t_snoop_race();
    t_snoop_fill();
    t_conflict();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule